// File: doc/BRIEF.md
# Timer compare-capture output unit

This block is one channel of an 8-bit up-counting timer. A free-running counter advances by one on every cycle in which the `tick` input is high. Two 8-bit registers, A and B, are compared against the counter. Each time a compare match occurs, one timer output pin is updated by an action chosen for that register: no change, drive low, drive high, or invert. When both registers match in the same cycle, one action is chosen by fixed priority. Invert ranks above drive high, and drive high ranks above drive low.

A capture-mode bit changes the role of register B. In capture mode, B stops acting as a compare register. The B select field then chooses an edge of the `cap_in` pin, and on that edge the counter value is stored in B. Software reaches the counter, both registers and the control bits through a small single-cycle write port with a combinational read port. The address map is: 0 = counter, 1 = register A, 2 = register B, 3 = control.

Top module: `tmr_cc_unit`

## Requirements
- R1: The counter increments by one at each clock edge where `tick` is 1, wrapping from 0xFF to 0x00. The counter holds its value when `tick` is 0.
- R2: A bus write to the counter (address 0) in a cycle where `tick` is also 1 loads the written value, and the increment is lost.
- R3: The control register (address 3) has these fields: bits [1:0] select the A action, bits [3:2] select the B field, and bit 4 is capture mode. The action encoding is 00 = keep, 01 = drive 0, 10 = drive 1, 11 = invert. A match on A happens at an edge where `tick` is 1 and the counter equals A. At that edge, `tmr_out` takes the selected level.
- R4: When capture mode is 0, register B matches the same way as A and applies its B field with the same encoding.
- R5: When A and B match at the same edge, the applied action is the higher one in the order invert > drive 1 > drive 0 > keep.
- R6: While all four select bits (control bits [3:0]) are 0, `tmr_out` holds its level.
- R7: After reset, `tmr_out` is 0, and the counter, A, B and the control register all read 0.
- R8: In capture mode, register B produces no compare match, and compare A still drives the output.
- R9: In capture mode, the B field selects the capture edge: 00 = rising, 01 = falling, 10 or 11 = both. On a qualifying edge of `cap_in`, the current counter value is loaded into B.
- R10: `cap_in` passes through a two-flop synchronizer. A change of `cap_in` before clock edge 1 loads B at edge 3, and B is unchanged after edge 2.
- R11: While capture mode is 1, a bus write to register B (address 2) is ignored. When capture mode is 0, the same write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable for the counter |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 counter, 1 A, 2 B, 3 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register, combinational |
| cap_in | input | 1 | Asynchronous capture input |
| tmr_out | output | 1 | Timer output pin |

## Verification
The hardest situation to reach from the ports is a cycle in which A and B match together. Reaching it needs both registers equal to the counter on exactly the edge where `tick` rises. The table of vectors therefore preloads the counter, A, B and the control field while `tick` is low, and then issues a single tick. This makes each priority pairing a single-edge event, with the output level known beforehand. Capture timing is reached by holding `tick` low so that the counter is frozen, and then moving `cap_in` on a falling clock edge. The edge at which B changes can then be counted exactly.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } act_e;

  typedef struct packed {
    logic       cap_en;
    logic [1:0] b_sel;
    logic [1:0] a_sel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [1:0] ADDR_CNT  = 2'd0;
  localparam logic [1:0] ADDR_CMPA = 2'd1;
  localparam logic [1:0] ADDR_CMPB = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  // The encoding order equals the priority order.
  function automatic act_e stronger(input act_e x, input act_e y);
    return (x > y) ? x : y;
  endfunction

  function automatic logic next_level(input logic cur, input act_e act);
    case (act)
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_FLIP: return ~cur;
      default:  return cur;
    endcase
  endfunction

  function automatic logic edge_hit(input logic [1:0] sel, input logic rise,
                                    input logic fall);
    if (sel[1]) return rise | fall;
    if (sel[0]) return fall;
    return rise;
  endfunction

endpackage

// File: rtl/tmr_cc_regs.sv
module tmr_cc_regs
  import tmr_cc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  input  logic          cap_load,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cmp_a,
  output logic [CW-1:0] cmp_b,
  output ctrl_t         ctrl,
  output logic          cnt_wr,
  output logic [CW-1:0] bus_rdata
);

  localparam int PAD_W = CW - CTRL_W;

  logic wr_a, wr_b, wr_ctrl;

  assign cnt_wr  = bus_wr && (bus_addr == ADDR_CNT);
  assign wr_a    = bus_wr && (bus_addr == ADDR_CMPA);
  assign wr_b    = bus_wr && (bus_addr == ADDR_CMPB) && !ctrl.cap_en;
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_wr) begin
      cnt <= bus_wdata;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a <= '0;
    end else if (wr_a) begin
      cmp_a <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_b <= '0;
    end else if (cap_load) begin
      cmp_b <= cnt;
    end else if (wr_b) begin
      cmp_b <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_ctrl) begin
      ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_CNT:  bus_rdata = cnt;
      ADDR_CMPA: bus_rdata = cmp_a;
      ADDR_CMPB: bus_rdata = cmp_b;
      default:   bus_rdata = {{PAD_W{1'b0}}, ctrl};
    endcase
  end

endmodule

// File: rtl/tmr_cc_edge.sv
module tmr_cc_edge
  import tmr_cc_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_in,
  input  logic       enable,
  input  logic [1:0] sel,
  output logic       rise,
  output logic       fall,
  output logic       cap_load
);

  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], cap_in};
      prev_q <= sync_q[TOP];
    end
  end

  assign rise     = sync_q[TOP] & ~prev_q;
  assign fall     = ~sync_q[TOP] & prev_q;
  assign cap_load = enable && edge_hit(sel, rise, fall);

endmodule

// File: rtl/tmr_cc_outsel.sv
module tmr_cc_outsel
  import tmr_cc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  input  ctrl_t         ctrl,
  output logic          match_a,
  output logic          match_b,
  output act_e          act,
  output logic          tmr_out
);

  logic out_en;
  act_e act_a, act_b;

  assign match_a = tick && (cnt == cmp_a);
  assign match_b = tick && !ctrl.cap_en && (cnt == cmp_b);
  assign act_a   = match_a ? act_e'(ctrl.a_sel) : ACT_KEEP;
  assign act_b   = match_b ? act_e'(ctrl.b_sel) : ACT_KEEP;
  assign act     = stronger(act_a, act_b);
  assign out_en  = |{ctrl.b_sel, ctrl.a_sel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_out <= 1'b0;
    end else if (out_en) begin
      tmr_out <= next_level(tmr_out, act);
    end
  end

endmodule

// File: rtl/tmr_cc_unit.sv
module tmr_cc_unit
  import tmr_cc_pkg::*;
#(
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic          cap_in,
  output logic          tmr_out
);

  logic [CW-1:0] cnt_q, cmp_a_q, cmp_b_q;
  ctrl_t         ctrl_q;
  logic          cnt_wr, cap_load, cap_rise, cap_fall;
  logic          match_a, match_b;
  act_e          act;

  tmr_cc_regs #(.CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cap_load  (cap_load),
    .cnt       (cnt_q),
    .cmp_a     (cmp_a_q),
    .cmp_b     (cmp_b_q),
    .ctrl      (ctrl_q),
    .cnt_wr    (cnt_wr),
    .bus_rdata (bus_rdata)
  );

  tmr_cc_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_in   (cap_in),
    .enable   (ctrl_q.cap_en),
    .sel      (ctrl_q.b_sel),
    .rise     (cap_rise),
    .fall     (cap_fall),
    .cap_load (cap_load)
  );

  tmr_cc_outsel #(.CW(CW)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .cnt     (cnt_q),
    .cmp_a   (cmp_a_q),
    .cmp_b   (cmp_b_q),
    .ctrl    (ctrl_q),
    .match_a (match_a),
    .match_b (match_b),
    .act     (act),
    .tmr_out (tmr_out)
  );

endmodule

// File: rtl/tmr_cc_unit_chk.sv
module tmr_cc_unit_chk
  import tmr_cc_pkg::*;
#(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          cnt_wr,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cmp_b,
  input ctrl_t         ctrl,
  input logic          match_a,
  input logic          match_b,
  input logic          cap_load,
  input logic          tmr_out
);

  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr) |=> (cnt == CW'($past(cnt) + 1'b1)));

  a_r1_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt));

  a_r8_no_b_match: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.cap_en |-> !match_b);

  a_r6_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.a_sel == 2'b00 && ctrl.b_sel == 2'b00) |=> $stable(tmr_out));

  a_r5_toggle_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((match_a && ctrl.a_sel == 2'b11) || (match_b && ctrl.b_sel == 2'b11))
      |=> (tmr_out != $past(tmr_out)));

  a_r3_drive_high: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a && ctrl.a_sel == 2'b10 && !(match_b && ctrl.b_sel == 2'b11))
      |=> tmr_out);

  a_r9_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
    cap_load |=> (cmp_b == $past(cnt)));

  a_r11_b_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.cap_en && !cap_load) |=> $stable(cmp_b));

endmodule

bind tmr_cc_unit tmr_cc_unit_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .cnt_wr   (cnt_wr),
  .cnt      (cnt_q),
  .cmp_b    (cmp_b_q),
  .ctrl     (ctrl_q),
  .match_a  (match_a),
  .match_b  (match_b),
  .cap_load (cap_load),
  .tmr_out  (tmr_out)
);

// File: tb/tmr_cc_unit_bench.sv
`timescale 1ns/1ps
module tmr_cc_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       cap_in = 1'b0;
  logic       tmr_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_cc_unit u_tmr_cc_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cap_in    (cap_in),
    .tmr_out   (tmr_out)
  );

  // Each vector is {ctrl[4:0], A, B, counter preload, expected output after one tick}.
  localparam int NV = 12;
  localparam logic [29:0] VECS [0:NV-1] = '{
    {5'b00010, 8'd5, 8'd9, 8'd5, 1'b1},  // R3 drive high
    {5'b00001, 8'd5, 8'd9, 8'd5, 1'b0},  // R3 drive low
    {5'b00011, 8'd5, 8'd9, 8'd5, 1'b1},  // R3 invert
    {5'b00011, 8'd5, 8'd9, 8'd6, 1'b1},  // R3 no match
    {5'b01001, 8'd7, 8'd7, 8'd7, 1'b1},  // R5 high over low
    {5'b01110, 8'd7, 8'd7, 8'd7, 1'b0},  // R5 invert over high
    {5'b00110, 8'd7, 8'd7, 8'd7, 1'b1},  // R5 high over low (B low)
    {5'b11100, 8'd3, 8'd3, 8'd3, 1'b1},  // R8 B silent in capture mode
    {5'b00001, 8'd2, 8'd3, 8'd2, 1'b0},  // R3 drive low
    {5'b00011, 8'd2, 8'd3, 8'd2, 1'b1},  // R3 invert
    {5'b00000, 8'd2, 8'd2, 8'd2, 1'b1},  // R6 disabled, hold
    {5'b10001, 8'd4, 8'd9, 8'd4, 1'b0}   // R8 A active in capture mode
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick_once();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset state
    #1 chk("R7 out", {7'd0, tmr_out}, 8'd0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk("R7 reg", d, 8'd0);
    end

    // Table walk
    for (int i = 0; i < NV; i++) begin
      wr(2'd1, VECS[i][24:17]);
      wr(2'd2, VECS[i][16:9]);
      wr(2'd0, VECS[i][8:1]);
      wr(2'd3, {3'd0, VECS[i][29:25]});
      tick_once();
      #1 chk("R3/R4/R5/R6/R8 out", {7'd0, tmr_out}, {7'd0, VECS[i][0]});
      rd(2'd0, d);
      chk("R1 step", d, VECS[i][8:1] + 8'd1);
    end

    // R11 bus write to B ignored in capture mode (capture still on from last vector)
    wr(2'd2, 8'h11);
    rd(2'd2, d);
    chk("R11 locked", d, 8'd9);

    // R9 / R10 rising-edge capture with synchronizer latency
    wr(2'd3, 8'b0001_0000);
    wr(2'd0, 8'h42);
    @(negedge clk);
    cap_in = 1'b1;
    bus_addr = 2'd2;
    @(negedge clk);
    @(negedge clk);
    #1 chk("R10 not yet", bus_rdata, 8'd9);
    @(negedge clk);
    #1 chk("R10 edge3", bus_rdata, 8'h42);
    chk("R9 rising", bus_rdata, 8'h42);

    // R9 rising mode ignores falling edge
    wr(2'd0, 8'h55);
    @(negedge clk); cap_in = 1'b0;
    wait_cyc(4);
    rd(2'd2, d);
    chk("R9 fall ignored", d, 8'h42);

    // R9 falling mode
    wr(2'd3, 8'b0001_0100);
    wr(2'd0, 8'h60);
    @(negedge clk); cap_in = 1'b1;
    wait_cyc(4);
    rd(2'd2, d);
    chk("R9 rise ignored", d, 8'h42);
    wr(2'd0, 8'h61);
    @(negedge clk); cap_in = 1'b0;
    wait_cyc(4);
    rd(2'd2, d);
    chk("R9 falling", d, 8'h61);

    // R9 both edges, code 10 and 11
    wr(2'd3, 8'b0001_1000);
    wr(2'd0, 8'h70);
    @(negedge clk); cap_in = 1'b1;
    wait_cyc(4);
    rd(2'd2, d);
    chk("R9 both rise", d, 8'h70);
    wr(2'd0, 8'h71);
    @(negedge clk); cap_in = 1'b0;
    wait_cyc(4);
    rd(2'd2, d);
    chk("R9 both fall", d, 8'h71);
    wr(2'd3, 8'b0001_1100);
    wr(2'd0, 8'h72);
    @(negedge clk); cap_in = 1'b1;
    wait_cyc(4);
    rd(2'd2, d);
    chk("R9 code 11", d, 8'h72);

    // R11 contrast: with capture off, B write takes effect
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h33);
    rd(2'd2, d);
    chk("R11 unlocked", d, 8'h33);

    // R1 wrap and hold
    wr(2'd0, 8'hFF);
    tick_once();
    rd(2'd0, d);
    chk("R1 wrap", d, 8'h00);
    wait_cyc(3);
    rd(2'd0, d);
    chk("R1 hold", d, 8'h00);

    // R2 write wins over tick
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h20; tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0;
    rd(2'd0, d);
    chk("R2 write wins", d, 8'h20);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule